// File: doc/BRIEF.md
# Decimal Multiply Exponent and Sticky Control

This block sits beside a decimal significand multiplier and produces the control values that the rounding stage needs, without waiting for the product to be aligned. From the two biased operand exponents it forms the preferred result exponent and the exponent of the double-width intermediate product. It counts the leading zero digits of both BCD significands and turns them into a sticky digit count.

That count is expanded into a per-digit mask across the 2n-digit intermediate product. The mask always leaves out the round and guard digits. The masked digits of the intermediate product are ORed into a sticky bit. Because the mask comes from the operands and not from the shifted product, the sticky bit is ready in the same cycle as the alignment shift instead of after it.

All results are captured in one register stage, qualified by a valid strobe.

Top module: `dmc_top`

## Requirements
- R1: `pref_exp_o` equals Ea + Eb − BIAS (BIAS = 398 by default), given as a two's-complement value EXP_W+2 bits wide.
- R2: `ip_exp_o` equals Ea + Eb − BIAS + N_DIG, in the same two's-complement format as `pref_exp_o`.
- R3: Leading zeros are counted in whole BCD digits from the most significant digit, and an all-zero significand counts as N_DIG. `sticky_cnt_o` equals max(0, N_DIG − (LZa + LZb)).
- R4: Digit k of the intermediate product sits at bits 4k+3..4k of `prod_i`, with digit 0 the least significant. `mask_o[k]` is 1 exactly when k < `sticky_cnt_o` − 2, so the mask is all zero when `sticky_cnt_o` ≤ 2.
- R5: `sticky_o` is 1 exactly when at least one digit whose mask bit is set has a nonzero BCD code. A digit at or above position `sticky_cnt_o` − 2 never affects it.
- R6: `valid_o` is `valid_i` delayed by one clock. The results that appear together with it belong to the inputs presented with that `valid_i`.
- R7: While `valid_i` is low, every result output holds its previous value, whatever the data inputs do.
- R8: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and product are valid |
| exp_a_i | input | EXP_W | Biased exponent of operand A |
| exp_b_i | input | EXP_W | Biased exponent of operand B |
| sig_a_i | input | 4*N_DIG | BCD significand of operand A |
| sig_b_i | input | 4*N_DIG | BCD significand of operand B |
| prod_i | input | 8*N_DIG | BCD intermediate product, 2*N_DIG digits |
| valid_o | output | 1 | Results valid |
| pref_exp_o | output | EXP_W+2 | Preferred exponent, two's complement |
| ip_exp_o | output | EXP_W+2 | Intermediate product exponent, two's complement |
| sticky_cnt_o | output | $clog2(N_DIG+1) | Sticky digit count before the two decrements |
| mask_o | output | 2*N_DIG | Per-digit sticky mask |
| sticky_o | output | 1 | Sticky bit |

## Verification
Operands with no leading zeros give the widest mask of fourteen digits. Leading-zero sums of 14 and 13 place the count exactly at 2 and at 3, which separates an empty mask from a single-digit mask. A lone nonzero product digit placed just inside the mask boundary and then just outside it shows whether the sticky OR stops at the right digit. Exponent extremes check the sign of the preferred exponent. Idle cycles with changing data check that the outputs hold, and randomly generated leading-zero counts and product digits cover the remaining combinations.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int unsigned DIGIT_W = 4;

  function automatic logic digit_nz(input logic [DIGIT_W-1:0] d);
    return |d;
  endfunction
endpackage

// File: rtl/dmc_lzc.sv
module dmc_lzc #(
  parameter int unsigned N_DIG = 16,
  parameter int unsigned CNT_W = $clog2(N_DIG + 1)
) (
  input  logic [4*N_DIG-1:0] sig_i,
  output logic [CNT_W-1:0]   lz_o
);
  import dmc_pkg::*;

  // last hit in ascending order is the highest nonzero digit
  always_comb begin
    lz_o = CNT_W'(N_DIG);
    for (int i = 0; i < int'(N_DIG); i++) begin
      if (digit_nz(sig_i[DIGIT_W*i +: DIGIT_W])) lz_o = CNT_W'(int'(N_DIG) - 1 - i);
    end
  end
endmodule

// File: rtl/dmc_exp.sv
module dmc_exp #(
  parameter int unsigned EXP_W = 10,
  parameter int unsigned BIAS  = 398,
  parameter int unsigned N_DIG = 16,
  parameter int unsigned XW    = EXP_W + 2
) (
  input  logic [EXP_W-1:0] exp_a_i,
  input  logic [EXP_W-1:0] exp_b_i,
  output logic [XW-1:0]    pref_o,
  output logic [XW-1:0]    eip_o
);
  localparam logic [XW-1:0] BIAS_X = XW'(BIAS);
  localparam logic [XW-1:0] NDIG_X = XW'(N_DIG);

  // modular arithmetic yields two's complement directly
  assign pref_o = XW'(exp_a_i) + XW'(exp_b_i) - BIAS_X;
  assign eip_o  = pref_o + NDIG_X;
endmodule

// File: rtl/dmc_sticky.sv
module dmc_sticky #(
  parameter int unsigned N_DIG = 16,
  parameter int unsigned CNT_W = $clog2(N_DIG + 1)
) (
  input  logic [CNT_W-1:0]   lz_a_i,
  input  logic [CNT_W-1:0]   lz_b_i,
  input  logic [8*N_DIG-1:0] prod_i,
  output logic [CNT_W-1:0]   sc_o,
  output logic [2*N_DIG-1:0] mask_o,
  output logic               sticky_o
);
  import dmc_pkg::*;

  localparam int unsigned SUM_W = CNT_W + 1;
  localparam int unsigned P_DIG = 2 * N_DIG;

  logic [SUM_W-1:0] lz_sum;
  logic [CNT_W-1:0] eff;
  logic [P_DIG-1:0] nz;

  assign lz_sum = SUM_W'(lz_a_i) + SUM_W'(lz_b_i);
  assign sc_o   = (lz_sum >= SUM_W'(N_DIG)) ? '0 : CNT_W'(SUM_W'(N_DIG) - lz_sum);
  // exclude round and guard digits
  assign eff    = (sc_o > CNT_W'(2)) ? sc_o - CNT_W'(2) : '0;

  for (genvar k = 0; k < int'(P_DIG); k++) begin : g_dig
    localparam logic [CNT_W:0] POS = (CNT_W + 1)'(k);
    assign mask_o[k] = {1'b0, eff} > POS;
    assign nz[k]     = digit_nz(prod_i[DIGIT_W*k +: DIGIT_W]);
  end

  assign sticky_o = |(mask_o & nz);
endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
  parameter int unsigned N_DIG = 16,
  parameter int unsigned EXP_W = 10,
  parameter int unsigned BIAS  = 398,
  localparam int unsigned CNT_W = $clog2(N_DIG + 1),
  localparam int unsigned XW    = EXP_W + 2,
  localparam int unsigned SIG_W = 4 * N_DIG,
  localparam int unsigned PRD_W = 8 * N_DIG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  input  logic [SIG_W-1:0]  sig_a_i,
  input  logic [SIG_W-1:0]  sig_b_i,
  input  logic [PRD_W-1:0]  prod_i,
  output logic              valid_o,
  output logic [XW-1:0]     pref_exp_o,
  output logic [XW-1:0]     ip_exp_o,
  output logic [CNT_W-1:0]  sticky_cnt_o,
  output logic [2*N_DIG-1:0] mask_o,
  output logic              sticky_o
);
  logic [CNT_W-1:0]   lz_a, lz_b, sc_d;
  logic [XW-1:0]      pref_d, eip_d;
  logic [2*N_DIG-1:0] mask_d;
  logic               sticky_d;

  dmc_lzc #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_lzc_a (.sig_i(sig_a_i), .lz_o(lz_a));
  dmc_lzc #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_lzc_b (.sig_i(sig_b_i), .lz_o(lz_b));

  dmc_exp #(.EXP_W(EXP_W), .BIAS(BIAS), .N_DIG(N_DIG), .XW(XW)) u_exp (
    .exp_a_i(exp_a_i), .exp_b_i(exp_b_i), .pref_o(pref_d), .eip_o(eip_d)
  );

  dmc_sticky #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_sticky (
    .lz_a_i(lz_a), .lz_b_i(lz_b), .prod_i(prod_i),
    .sc_o(sc_d), .mask_o(mask_d), .sticky_o(sticky_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      pref_exp_o   <= '0;
      ip_exp_o     <= '0;
      sticky_cnt_o <= '0;
      mask_o       <= '0;
      sticky_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pref_exp_o   <= pref_d;
        ip_exp_o     <= eip_d;
        sticky_cnt_o <= sc_d;
        mask_o       <= mask_d;
        sticky_o     <= sticky_d;
      end
    end
  end

  p_eip_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ip_exp_o - pref_exp_o) == XW'(N_DIG));

  p_sc_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_cnt_o <= CNT_W'(N_DIG));

  p_mask_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mask_o) == ((sticky_cnt_o > CNT_W'(2)) ? int'(sticky_cnt_o) - 2 : 0));

  p_mask_contig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_o + 1'b1) & mask_o) == '0);

  p_sticky_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0) |-> !sticky_o);

  p_valid_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(mask_o) && $stable(sticky_o) && $stable(pref_exp_o)
                  && $stable(ip_exp_o) && $stable(sticky_cnt_o)));
endmodule

// File: tb/dmc_top_tb.sv
module dmc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int EW = 10;
  localparam int XW = EW + 2;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vi = 1'b0;
  logic [EW-1:0] ea = '0, eb = '0;
  logic [4*N-1:0] sa = '0, sb = '0;
  logic [8*N-1:0] pr = '0;
  logic vo;
  logic [XW-1:0] pref, eip;
  logic [CW-1:0] sc;
  logic [2*N-1:0] mask;
  logic sticky;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  bit e_valid = 0;
  int e_pref = 0, e_eip = 0, e_sc = 0;
  logic [2*N-1:0] e_mask = '0;
  bit e_sticky = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vi),
    .exp_a_i(ea), .exp_b_i(eb), .sig_a_i(sa), .sig_b_i(sb), .prod_i(pr),
    .valid_o(vo), .pref_exp_o(pref), .ip_exp_o(eip), .sticky_cnt_o(sc),
    .mask_o(mask), .sticky_o(sticky)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lzd(input logic [4*N-1:0] s);
    int z = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (s[4*i +: 4] != 0) break;
      z++;
    end
    return z;
  endfunction

  function automatic logic [4*N-1:0] mk_sig(input int lz);
    logic [4*N-1:0] s = '0;
    for (int i = 0; i < N - lz; i++) begin
      if (i == N - lz - 1) s[4*i +: 4] = 4'(1 + $urandom % 9);
      else s[4*i +: 4] = 4'($urandom % 10);
    end
    return s;
  endfunction

  task automatic model();
    int s, eff;
    s = N - (lzd(sa) + lzd(sb));
    if (s < 0) s = 0;
    eff = (s > 2) ? s - 2 : 0;
    e_pref = int'(ea) + int'(eb) - 398;
    e_eip = e_pref + N;
    e_sc = s;
    e_mask = '0;
    e_sticky = 0;
    for (int k = 0; k < 2 * N; k++) begin
      if (k < eff) begin
        e_mask[k] = 1'b1;
        if (pr[4*k +: 4] != 0) e_sticky = 1;
      end
    end
  endtask

  task automatic compare();
    chk(vo == e_valid, "R6 valid_o", vo, e_valid);
    chk(int'($signed(pref)) == e_pref, "R1 pref_exp", int'($signed(pref)), e_pref);
    chk(int'($signed(eip)) == e_eip, "R2 ip_exp", int'($signed(eip)), e_eip);
    chk(int'(sc) == e_sc, "R3 sticky_cnt", sc, e_sc);
    chk(mask == e_mask, "R4 mask", mask, e_mask);
    chk(sticky == e_sticky, "R5 sticky", sticky, e_sticky);
  endtask

  // drive at negedge, model, then sample a quarter period after the next posedge
  task automatic step(input bit v, input int a, input int b,
                      input logic [4*N-1:0] xa, input logic [4*N-1:0] xb,
                      input logic [8*N-1:0] p);
    @(negedge clk);
    vi = v; ea = EW'(a); eb = EW'(b); sa = xa; sb = xb; pr = p;
    if (v) model();
    e_valid = v;   // R7: when idle the result state is kept
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare();
  endtask

  initial begin
    logic [8*N-1:0] p;
    logic [4*N-1:0] nines;
    nines = '0;
    for (int i = 0; i < N; i++) nines[4*i +: 4] = 4'd9;

    // R8 reset state
    repeat (2) @(negedge clk);
    chk(vo == 0 && pref == 0 && eip == 0, "R8 reset exp/valid", {vo, pref, eip}, 0);
    chk(sc == 0 && mask == 0 && sticky == 0, "R8 reset sticky", {sc, mask, sticky}, 0);
    rst_n = 1'b1;

    // R4 widest mask, zero product -> sticky 0
    step(1, 398, 398, nines, nines, '0);
    // R5 digit 13 inside mask
    p = '0; p[4*13 +: 4] = 4'd5;
    step(1, 398, 398, nines, nines, p);
    // R5 digit 14 just outside mask
    p = '0; p[4*14 +: 4] = 4'd7;
    step(1, 398, 398, nines, nines, p);
    // R4 count exactly 2 -> empty mask
    p = '1;
    for (int i = 0; i < 2 * N; i++) p[4*i +: 4] = 4'd9;
    step(1, 100, 200, mk_sig(7), mk_sig(7), p);
    // R4 count 3 -> only digit 0
    p = '0; p[3:0] = 4'd1;
    step(1, 100, 200, mk_sig(7), mk_sig(6), p);
    // R3 all-zero significand counts N
    step(1, 500, 300, '0, nines, p);
    // R1 exponent extremes
    step(1, 0, 0, nines, mk_sig(3), p);
    step(1, 767, 767, mk_sig(2), mk_sig(1), p);
    // R7 idle with changing data
    step(0, 5, 9, mk_sig(0), mk_sig(0), '1);
    step(0, 700, 1, '0, '0, '0);
    // random
    for (int t = 0; t < 400; t++) begin
      logic [8*N-1:0] rp;
      rp = '0;
      for (int k = 0; k < 2 * N; k++)
        if ($urandom % 4 == 0) rp[4*k +: 4] = 4'(1 + $urandom % 9);
      step(($urandom % 5) != 0, $urandom % 768, $urandom % 768,
           mk_sig($urandom % (N + 1)), mk_sig($urandom % (N + 1)), rp);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule